// File: doc/BRIEF.md
# Shared-ROM Multiprocessor Boot Sequencer

This block sequences the boot of several processor agents that share a single boot ROM. After reset, every agent is idle with its bus request low. It then reads its boot-mode strap. Agents strapped for ROM boot raise a request. A fixed-priority arbiter hands the ROM bus to one agent at a time. The copy engine streams a fixed-length image of `IMG_WORDS` words from the ROM into the owner's local program memory, and the owner then drops its request and releases the bus.

An agent can load either a shared image that every agent reads from ROM region 0, or its own image in a region selected by its agent index. Agents strapped for a non-ROM boot never touch the bus and count as finished at once. When every agent is finished, a single start flag rises for all of them together and stays high until reset.

The ROM has a read latency of one cycle. Each word it returns is registered before it is written into the owner's local memory, so the write ports come straight from flops and suit block RAM.

Top module: `boot_seq_top`

## Requirements
- R1: While synchronous active-high reset is applied, all grants, all memory write enables, all done flags, the ROM chip-select and the start flag are 0.
- R2: Boot-mode strap encoding per agent (bits [2i+1:2i] of the strap bus): 00 = non-ROM boot, 01 = shared image, 10 or 11 = own image. A 00 agent is never granted, receives no memory writes, and has its done flag set within 2 cycles after reset is released.
- R3: At most one grant is high in any cycle, and the ROM chip-select is high only while a grant is held.
- R4: ROM-boot agents are served in ascending index order, so agent 0 has the highest priority.
- R5: Each ROM-boot agent receives exactly `IMG_WORDS` writes on its own write enable only, at local addresses 0, 1, …, `IMG_WORDS`-1 in that order.
- R6: The word written at local address k is the ROM word at address k for a shared-image agent, and at address ID*`IMG_WORDS`+k for an own-image agent. The ROM returns data one cycle after it samples the address.
- R7: After its last write the owner releases the bus, and at least one cycle with no grant separates the grants of two different agents.
- R8: An agent's done flag rises only after its last memory write and stays high until reset.
- R9: The start flag rises only once every done flag is high, follows the last done flag within 2 cycles, and then stays high until reset.
- R10: When every agent is strapped 00, the start flag rises within 3 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode_i | input | 2*N_AGENTS | Per-agent boot-mode strap, 2 bits per agent |
| rom_cs_o | output | 1 | Shared ROM chip-select (read enable) |
| rom_addr_o | output | clog2(N_AGENTS*IMG_WORDS) | ROM word address |
| rom_data_i | input | DATA_W | ROM read data, valid one cycle after the address is sampled |
| grant_o | output | N_AGENTS | Bus grant, one bit per agent |
| mem_we_o | output | N_AGENTS | Local program memory write enable, one bit per agent |
| mem_addr_o | output | clog2(IMG_WORDS) | Local memory write address, shared by all agents |
| mem_data_o | output | DATA_W | Local memory write data, shared by all agents |
| done_o | output | N_AGENTS | Per-agent boot-finished flag |
| start_o | output | 1 | Common start, high once all agents are finished |

## Verification
The bound checker watches the invariants that hold on every cycle:
- a single grant at most, and a chip-select only under a grant;
- writes that go only to the current owner;
- a grant that never passes straight from one agent to another;
- done and start flags that never fall;
- a start flag that never leads the done flags.

What only the bench's scenarios can show is the content of each boot. That covers the write count, the addresses, the data fetched from the region chosen by the strap, the order of service across many strap mixes, and how soon start follows the last done flag or reset when no agent boots from ROM.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  // Per-agent boot-mode strap encoding
  localparam logic [1:0] MODE_NONE   = 2'b00;
  localparam logic [1:0] MODE_SHARED = 2'b01;

  typedef enum logic [1:0] {
    AG_IDLE = 2'd0,
    AG_REQ  = 2'd1,
    AG_DONE = 2'd2
  } agent_state_e;

  typedef enum logic [1:0] {
    EN_IDLE = 2'd0,
    EN_RUN  = 2'd1,
    EN_WAIT = 2'd2
  } engine_state_e;
endpackage

// File: rtl/boot_agent.sv
module boot_agent
  import boot_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       finish_i,
  output logic       req_o,
  output logic       own_img_o,
  output logic       done_o
);
  agent_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= AG_IDLE;
      done_o    <= 1'b0;
      own_img_o <= 1'b0;
    end else begin
      case (state_q)
        AG_IDLE: begin
          own_img_o <= mode_i[1];
          if (mode_i == MODE_NONE) begin
            state_q <= AG_DONE;
            done_o  <= 1'b1;
          end else begin
            state_q <= AG_REQ;
          end
        end
        AG_REQ: begin
          if (finish_i) begin
            state_q <= AG_DONE;
            done_o  <= 1'b1;
          end
        end
        default: state_q <= AG_DONE;
      endcase
    end
  end

  assign req_o = (state_q == AG_REQ);
endmodule

// File: rtl/boot_arbiter.sv
module boot_arbiter #(
  parameter int N_AGENTS = 4,
  localparam int IDW = $clog2(N_AGENTS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_AGENTS-1:0] req_i,
  output logic [N_AGENTS-1:0] grant_o,
  output logic [IDW-1:0]      owner_o
);
  logic [N_AGENTS-1:0] pick;
  logic [IDW-1:0]      pick_id;

  // Lowest index wins
  always_comb begin
    pick    = '0;
    pick_id = '0;
    for (int i = N_AGENTS - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
        pick_id = IDW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= '0;
      owner_o <= '0;
    end else if (|grant_o) begin
      // hold until the owner drops its request, then leave one idle cycle
      if ((grant_o & req_i) == '0) grant_o <= '0;
    end else if (|req_i) begin
      grant_o <= pick;
      owner_o <= pick_id;
    end
  end
endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine
  import boot_seq_pkg::*;
#(
  parameter int N_AGENTS  = 4,
  parameter int IMG_WORDS = 256,
  parameter int DATA_W    = 32,
  localparam int IDW = $clog2(N_AGENTS),
  localparam int MAW = $clog2(IMG_WORDS),
  localparam int RAW = $clog2(N_AGENTS * IMG_WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_AGENTS-1:0] grant_i,
  input  logic [IDW-1:0]      owner_i,
  input  logic                own_img_i,
  output logic                rom_cs_o,
  output logic [RAW-1:0]      rom_addr_o,
  input  logic [DATA_W-1:0]   rom_data_i,
  output logic [N_AGENTS-1:0] wr_we_o,
  output logic [MAW-1:0]      wr_addr_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic [N_AGENTS-1:0] finish_o
);
  localparam logic [MAW-1:0] LAST = MAW'(IMG_WORDS - 1);

  engine_state_e    st_q;
  logic [MAW-1:0]   rd_idx_q;
  logic             vld2_q;
  logic [MAW-1:0]   idx2_q;
  logic [RAW-1:0]   base;

  assign base = own_img_i ? RAW'(owner_i) * RAW'(IMG_WORDS) : '0;

  // Issue stage
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= EN_IDLE;
      rom_cs_o   <= 1'b0;
      rom_addr_o <= '0;
      rd_idx_q   <= '0;
    end else begin
      case (st_q)
        EN_IDLE: begin
          if (|grant_i) begin
            st_q       <= EN_RUN;
            rom_cs_o   <= 1'b1;
            rom_addr_o <= base;
            rd_idx_q   <= '0;
          end
        end
        EN_RUN: begin
          if (rd_idx_q == LAST) begin
            rom_cs_o <= 1'b0;
            st_q     <= EN_WAIT;
          end else begin
            rd_idx_q   <= rd_idx_q + 1'b1;
            rom_addr_o <= rom_addr_o + 1'b1;
          end
        end
        EN_WAIT: if (grant_i == '0) st_q <= EN_IDLE;
        default: st_q <= EN_IDLE;
      endcase
    end
  end

  // ROM access stage and write stage
  always_ff @(posedge clk) begin
    if (rst) begin
      vld2_q    <= 1'b0;
      idx2_q    <= '0;
      wr_we_o   <= '0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      finish_o  <= '0;
    end else begin
      vld2_q   <= rom_cs_o;
      idx2_q   <= rd_idx_q;
      wr_we_o  <= vld2_q ? grant_i : '0;
      finish_o <= (vld2_q && idx2_q == LAST) ? grant_i : '0;
      if (vld2_q) begin
        wr_addr_o <= idx2_q;
        wr_data_o <= rom_data_i;
      end
    end
  end
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int N_AGENTS  = 4,
  parameter int IMG_WORDS = 256,
  parameter int DATA_W    = 32,
  localparam int IDW = $clog2(N_AGENTS),
  localparam int MAW = $clog2(IMG_WORDS),
  localparam int RAW = $clog2(N_AGENTS * IMG_WORDS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*N_AGENTS-1:0] boot_mode_i,
  output logic                  rom_cs_o,
  output logic [RAW-1:0]        rom_addr_o,
  input  logic [DATA_W-1:0]     rom_data_i,
  output logic [N_AGENTS-1:0]   grant_o,
  output logic [N_AGENTS-1:0]   mem_we_o,
  output logic [MAW-1:0]        mem_addr_o,
  output logic [DATA_W-1:0]     mem_data_o,
  output logic [N_AGENTS-1:0]   done_o,
  output logic                  start_o
);
  logic [N_AGENTS-1:0] req;
  logic [N_AGENTS-1:0] own_img;
  logic [N_AGENTS-1:0] finish;
  logic [IDW-1:0]      owner;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    boot_agent i_agent (
      .clk      (clk),
      .rst      (rst),
      .mode_i   (boot_mode_i[2*g +: 2]),
      .finish_i (finish[g]),
      .req_o    (req[g]),
      .own_img_o(own_img[g]),
      .done_o   (done_o[g])
    );
  end

  boot_arbiter #(.N_AGENTS(N_AGENTS)) i_arb (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req),
    .grant_o(grant_o),
    .owner_o(owner)
  );

  boot_copy_engine #(
    .N_AGENTS (N_AGENTS),
    .IMG_WORDS(IMG_WORDS),
    .DATA_W   (DATA_W)
  ) i_eng (
    .clk       (clk),
    .rst       (rst),
    .grant_i   (grant_o),
    .owner_i   (owner),
    .own_img_i (own_img[owner]),
    .rom_cs_o  (rom_cs_o),
    .rom_addr_o(rom_addr_o),
    .rom_data_i(rom_data_i),
    .wr_we_o   (mem_we_o),
    .wr_addr_o (mem_addr_o),
    .wr_data_o (mem_data_o),
    .finish_o  (finish)
  );

  // Start barrier: sticky once every agent is finished
  always_ff @(posedge clk) begin
    if (rst) start_o <= 1'b0;
    else     start_o <= start_o | (&done_o);
  end
endmodule

// File: rtl/boot_seq_checker.sv
module boot_seq_checker #(
  parameter int N_AGENTS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [N_AGENTS-1:0] grant_o,
  input logic                rom_cs_o,
  input logic [N_AGENTS-1:0] mem_we_o,
  input logic [N_AGENTS-1:0] done_o,
  input logic                start_o
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(grant_o)); // R3
  AST_CS_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst) rom_cs_o |-> (grant_o != '0)); // R3
  AST_WE_TO_OWNER: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o != '0) |-> ($onehot(mem_we_o) && ((mem_we_o & ~grant_o) == '0))); // R5
  AST_GRANT_GAP: assert property (@(posedge clk) disable iff (rst)
    (grant_o != '0) |=> (grant_o == '0 || grant_o == $past(grant_o))); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done_o != '0) |=> ((done_o & $past(done_o)) == $past(done_o))); // R8
  AST_START_STICKY: assert property (@(posedge clk) disable iff (rst) start_o |=> start_o); // R9
  AST_START_ALL_DONE: assert property (@(posedge clk) disable iff (rst) start_o |-> (&done_o)); // R9
endmodule

bind boot_seq_top boot_seq_checker #(.N_AGENTS(N_AGENTS)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .grant_o (grant_o),
  .rom_cs_o(rom_cs_o),
  .mem_we_o(mem_we_o),
  .done_o  (done_o),
  .start_o (start_o)
);

// File: tb/test_boot_seq_top.sv
module test_boot_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int IMG = 256;
  localparam int DW  = 32;
  localparam int MAW = $clog2(IMG);
  localparam int RAW = $clog2(N * IMG);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [2*N-1:0]  boot_mode = '0;
  logic            rom_cs;
  logic [RAW-1:0]  rom_addr;
  logic [DW-1:0]   rom_q = '0;
  logic [N-1:0]    grant, mem_we, done;
  logic [MAW-1:0]  mem_addr;
  logic [DW-1:0]   mem_data;
  logic            start;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  int wcnt[N];
  int last_wr[N];
  int done_cyc[N];
  int serve[N];
  int nserved;
  int start_cyc;
  int alldone_cyc;
  int gap_bad;
  logic [N-1:0] grant_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_seq_top #(.N_AGENTS(N), .IMG_WORDS(IMG), .DATA_W(DW)) i_boot_seq_top (
    .clk(clk), .rst(rst), .boot_mode_i(boot_mode),
    .rom_cs_o(rom_cs), .rom_addr_o(rom_addr), .rom_data_i(rom_q),
    .grant_o(grant), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_data_o(mem_data), .done_o(done), .start_o(start)
  );

  function automatic logic [DW-1:0] rom_word(input int a);
    logic [31:0] x;
    x = 32'(a);
    return (x * 32'h9E3779B1) ^ 32'hA5C30F1E ^ (x << 7);
  endfunction

  function automatic logic [1:0] mode_of(input int i);
    return boot_mode[2*i +: 2];
  endfunction

  function automatic int exp_base(input int i);
    return mode_of(i)[1] ? i * IMG : 0;
  endfunction

  // ROM model with one cycle of read latency
  always @(posedge clk) if (rom_cs) rom_q <= rom_word(int'(rom_addr));

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        wcnt[i] = 0; last_wr[i] = -1; done_cyc[i] = -1; serve[i] = -1;
      end
      nserved = 0; start_cyc = -1; alldone_cyc = -1; gap_bad = 0;
      grant_prev = '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (mem_we[i]) begin
          chk(mode_of(i) != 2'b00, "R2", "write to non-ROM agent", i, -1);
          chk(mem_addr == MAW'(wcnt[i]), "R5", "local write address", mem_addr, wcnt[i]);
          chk(mem_data == rom_word(exp_base(i) + wcnt[i]), "R6", "written word",
              mem_data, rom_word(exp_base(i) + wcnt[i]));
          wcnt[i]++;
          last_wr[i] = cyc;
        end
        if (done[i] && done_cyc[i] < 0) done_cyc[i] = cyc;
      end
      if (grant != '0 && grant_prev == '0) begin
        for (int i = 0; i < N; i++)
          if (grant[i] && nserved < N) begin serve[nserved] = i; nserved++; end
      end
      if (grant != '0 && grant_prev != '0 && grant != grant_prev) gap_bad++;
      if ((&done) && alldone_cyc < 0) alldone_cyc = cyc;
      if (start && start_cyc < 0) start_cyc = cyc;
      grant_prev = grant;
    end
  end

  task automatic run_case(input logic [2*N-1:0] modes, input string name);
    int exp_order[N];
    int nexp;
    boot_mode = modes;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(grant == '0 && mem_we == '0 && done == '0 && !start && !rom_cs, "R1",
        {"reset state ", name}, {grant, mem_we, done, start, rom_cs}, 0);
    rst = 1'b0;
    for (int k = 0; k < N * (IMG + 16) + 64 && !start; k++) @(posedge clk);
    repeat (4) @(negedge clk);
    nexp = 0;
    for (int i = 0; i < N; i++) if (mode_of(i) != 2'b00) begin exp_order[nexp] = i; nexp++; end
    chk(start, "R9", {"start high ", name}, start, 1);
    chk(start_cyc > alldone_cyc && start_cyc - alldone_cyc <= 2, "R9",
        {"start after last done ", name}, start_cyc, alldone_cyc + 1);
    chk(nserved == nexp, "R4", {"agents served ", name}, nserved, nexp);
    for (int j = 0; j < nexp && j < nserved; j++)
      chk(serve[j] == exp_order[j], "R4", {"service order ", name}, serve[j], exp_order[j]);
    chk(gap_bad == 0, "R7", {"direct grant handover ", name}, gap_bad, 0);
    for (int i = 0; i < N; i++) begin
      chk(done[i], "R8", {"done flag ", name}, done[i], 1);
      if (mode_of(i) == 2'b00) begin
        chk(wcnt[i] == 0, "R2", {"writes to non-ROM agent ", name}, wcnt[i], 0);
        chk(done_cyc[i] >= 1 && done_cyc[i] <= 2, "R2", {"non-ROM done time ", name}, done_cyc[i], 1);
      end else begin
        chk(wcnt[i] == IMG, "R5", {"write count ", name}, wcnt[i], IMG);
        chk(done_cyc[i] > last_wr[i], "R8", {"done after last write ", name}, done_cyc[i], last_wr[i] + 1);
      end
    end
    if (modes == '0)
      chk(start_cyc >= 1 && start_cyc <= 3, "R10", "start with no ROM boot", start_cyc, 2);
  endtask

  initial begin
    int seed;
    seed = int'($urandom(32'd20240611));
    run_case({2'b10, 2'b10, 2'b10, 2'b10}, "all own");
    run_case('0, "none");
    run_case({2'b01, 2'b00, 2'b00, 2'b00}, "only top shared");
    run_case({2'b11, 2'b01, 2'b00, 2'b10}, "mixed");
    run_case({2'b01, 2'b01, 2'b01, 2'b01}, "all shared");
    for (int r = 0; r < 5; r++) begin
      logic [2*N-1:0] m;
      m = (2*N)'($urandom());
      run_case(m, "random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not end");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule